// File: doc/BRIEF.md
# Serial EEPROM Slave with Block Protection

This block is the serial front end of a byte-addressed nonvolatile memory, with the storage array modelled inside it. A host talks to it over a four-wire SPI link: clock, data in, data out and an active-low select. Two more active-low pins are provided. One pauses a transfer in mid-stream. The other freezes the protection setting. The block decodes an 8-bit command, then a 16-bit address where the command needs one, then data. Reads run sequentially through the array. Writes collect up to one 32-byte page.

A write only takes effect if an enable latch was set beforehand. The write starts when select rises on a byte boundary. It then runs for a parameterized number of system clocks that stands in for the self-timed programming interval. The in-progress bit of the status register stays set for that whole interval. Two status bits lock the upper quarter, the upper half or all of the array against writes.

The SPI pins are sampled by the system clock through two-flop synchronizers. Each SCK level must therefore last at least four system clocks. The array holds 2^ADDR_W bytes. ADDR_W = 14 gives the full 16K x 8 organization. The default of 11 keeps elaboration small.

Top module: `spi_nvm_slave`

## Requirements
- R1: READ (0x03) followed by a 16-bit address returns the stored byte at that address. Address bits at and above ADDR_W are ignored.
- R2: Both SPI mode 0 (SCK idles low) and mode 3 (SCK idles high) work. SI is sampled on rising SCK and SO changes on falling SCK.
- R3: A read continues as long as clocks arrive and the address increments after each byte. After address 2^ADDR_W-1 the read continues at address 0.
- R4: WRITE (0x02) with an address and 1 to 32 data bytes programs those bytes. When the address runs past the end of the 32-byte page, it wraps to the start of the same page. Nothing is programmed before select rises.
- R5: WREN (0x06) sets the enable latch and WRDI (0x04) clears it. A WRITE or a status write issued while the latch is clear leaves the array and the status unchanged and does not start a write cycle.
- R6: RDSR (0x05) returns the status byte repeatedly for as long as it is clocked. The byte holds the in-progress flag in bit 0, the enable latch in bit 1 and the protect field in bits 3:2. Bits 7:4 read zero. All fields are zero after reset.
- R7: The protect field blocks writes to a range of the array: 00 blocks nothing, 01 the top quarter, 10 the top half, 11 everything. A WRITE aimed at a blocked page changes no byte and starts no write cycle, and the latch stays set.
- R8: WRSR (0x01) loads bits 3:2 of its data byte into the protect field. While wp_n is low, WRSR is rejected and the field keeps its value.
- R9: While hold_n is low, SCK and SI are ignored and so_en is low. After hold_n goes high, the transfer continues with the next bit.
- R10: While cs_n is high, so_en is low. Raising cs_n ends the command. A WRITE ended inside a data byte programs nothing and starts no write cycle.
- R11: An accepted write or status write holds the in-progress flag for WR_CYCLES clocks. During that time every command except RDSR is ignored. At the end of the cycle the enable latch clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all SPI pins are sampled with it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low pause of the current transfer |
| wp_n | input | 1 | Active-low lock of the status register |
| so | output | 1 | Serial data to the host |
| so_en | output | 1 | Drive enable for the so pad; low means released |

## Verification
Assertions check on every cycle the following:
- the array is never written at a blocked address;
- a write cycle only begins with the enable latch set;
- the latch is clear when the in-progress flag falls;
- the protect field only changes while wp_n was high;
- the bit counter stays frozen under hold;
- the timer stays busy until its count expires.

Only the bench's scenarios can show whether serial data moves correctly in both SPI modes. The same holds for page wrap, read wrap past the last address, aborting a write mid-byte, and that commands are ignored during a busy cycle. These are compared against a byte model of the array kept in the bench.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_AHI,
    PH_ALO,
    PH_WDATA,
    PH_SRDATA,
    PH_OUT,
    PH_IGN
  } phase_t;

  // Protect field against the two top address bits of a location.
  function automatic logic prot_hit(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return (top2 == 2'b11);
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/sx_pin_sync.sv
module sx_pin_sync #(
  parameter int N = 1,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= din[g];
        sync_q <= meta_q;
      end
    end
    assign dout[g] = sync_q;
  end

endmodule

// File: rtl/sx_wr_timer.sv
module sx_wr_timer #(
  parameter int CYCLES = 250000,
  parameter int CW     = $clog2(CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_d = 1'b0;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == LAST);
  assign cnt  = cnt_q;

  // R11: a cycle starts from a count of zero and is never restarted
  a_r11_start_clean: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q && (cnt_q == '0));
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  // R11: busy persists until the final count
  a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cnt_q != LAST)) |=> busy_q);

endmodule

// File: rtl/sx_page_buf.sv
module sx_page_buf #(
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [PAGE_W-1:0] widx,
  input  logic [7:0]        wdata,
  input  logic [PAGE_W-1:0] ridx,
  output logic [7:0]        rdata,
  output logic              rvalid
);

  localparam int PAGE = 1 << PAGE_W;

  logic [7:0]      data_q [PAGE];
  logic [PAGE-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (clr)     mask_d = '0;
    else if (wr) mask_d[widx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  always_ff @(posedge clk) begin
    if (wr && !clr) data_q[widx] <= wdata;
  end

  assign rdata  = data_q[ridx];
  assign rvalid = mask_q[ridx];

endmodule

// File: rtl/spi_nvm_slave.sv
module spi_nvm_slave
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic si,
  input  logic cs_n,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_en
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam int CW    = $clog2(WR_CYCLES + 1);

  initial begin
    if (ADDR_W < 9 || ADDR_W > 16 || PG_W < 2 || WR_CYCLES < PAGE)
      $error("spi_nvm_slave: unsupported parameter set");
  end

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  // pin synchronizers
  logic sck_s, si_s, csn_s, holdn_s, wpn_s;
  sx_pin_sync #(.N(5), .RST_VAL(5'b00111)) u_sync (
    .clk  (clk),
    .rst_n(rst_s_n),
    .din  ({sck, si, cs_n, hold_n, wp_n}),
    .dout ({sck_s, si_s, csn_s, holdn_s, wpn_s})
  );

  logic sck_q, csn_q;
  logic cs_act, hold_act, rise, fall, cs_end;
  assign cs_act   = !csn_s;
  assign hold_act = !holdn_s;
  assign rise     = cs_act && !hold_act &&  sck_s && !sck_q;
  assign fall     = cs_act && !hold_act && !sck_s &&  sck_q;
  assign cs_end   = csn_s && !csn_q;

  // state registers
  phase_t            ph_q, ph_d;
  logic [2:0]        bcnt_q, bcnt_d, obit_q, obit_d;
  logic [6:0]        sr_q, sr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        osr_q, osr_d;
  logic [1:0]        bp_q, bp_d, srnew_q, srnew_d;
  logic [PG_W-1:0]   page_q, page_d;
  logic              is_rd_q, is_rd_d, src_st_q, src_st_d, wel_q, wel_d;
  logic              wr_arm_q, wr_arm_d, sr_arm_q, sr_arm_d, commit_q, commit_d;

  // shared datapath
  logic          wip, tm_done, tm_start, wr_go, sr_go;
  logic [CW-1:0] tm_cnt;
  logic          pb_clr, pb_wr, pb_rvalid, byte_done, mem_we;
  logic [7:0]    pb_rdata, in_byte, st_byte, mem_rd;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]    mem [DEPTH];

  assign byte_done = rise && (bcnt_q == 3'd7);
  assign in_byte   = {sr_q, si_s};
  assign st_byte   = {4'b0000, bp_q, wel_q, wip};
  assign mem_rd    = mem[addr_q];

  assign wr_go = cs_end && wr_arm_q && (bcnt_q == 3'd0) && wel_q && !wip &&
                 !prot_hit(bp_q, addr_q[ADDR_W-1 -: 2]);
  assign sr_go = cs_end && sr_arm_q && (bcnt_q == 3'd0) && wel_q && !wip && wpn_s;
  assign tm_start = wr_go || sr_go;

  sx_wr_timer #(.CYCLES(WR_CYCLES), .CW(CW)) u_tmr (
    .clk  (clk),
    .rst_n(rst_s_n),
    .start(tm_start),
    .busy (wip),
    .done (tm_done),
    .cnt  (tm_cnt)
  );

  sx_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
    .clk   (clk),
    .rst_n (rst_s_n),
    .clr   (pb_clr),
    .wr    (pb_wr),
    .widx  (addr_q[PAGE_W-1:0]),
    .wdata (in_byte),
    .ridx  (tm_cnt[PAGE_W-1:0]),
    .rdata (pb_rdata),
    .rvalid(pb_rvalid)
  );

  assign mem_we    = commit_q && wip && (tm_cnt < CW'(PAGE)) && pb_rvalid;
  assign mem_waddr = {page_q, tm_cnt[PAGE_W-1:0]};

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= pb_rdata;
  end

  // next state
  always_comb begin
    ph_d     = ph_q;     bcnt_d   = bcnt_q;   obit_d  = obit_q;
    sr_d     = sr_q;     addr_d   = addr_q;   osr_d   = osr_q;
    bp_d     = bp_q;     srnew_d  = srnew_q;  page_d  = page_q;
    is_rd_d  = is_rd_q;  src_st_d = src_st_q; wel_d   = wel_q;
    wr_arm_d = wr_arm_q; sr_arm_d = sr_arm_q; commit_d = commit_q;
    pb_clr   = 1'b0;     pb_wr    = 1'b0;

    if (!cs_act) begin
      ph_d     = PH_OPC;
      bcnt_d   = 3'd0;
      obit_d   = 3'd0;
      wr_arm_d = 1'b0;
      sr_arm_d = 1'b0;
    end else begin
      if (rise) begin
        sr_d   = {sr_q[5:0], si_s};
        bcnt_d = bcnt_q + 3'd1;
      end
      if (byte_done) begin
        case (ph_q)
          PH_OPC: begin
            if (wip && in_byte != OP_RDSR) ph_d = PH_IGN;
            else begin
              case (in_byte)
                OP_WREN:  begin wel_d = 1'b1; ph_d = PH_IGN; end
                OP_WRDI:  begin wel_d = 1'b0; ph_d = PH_IGN; end
                OP_RDSR:  begin src_st_d = 1'b1; ph_d = PH_OUT; end
                OP_WRSR:  ph_d = PH_SRDATA;
                OP_READ:  begin is_rd_d = 1'b1; ph_d = PH_AHI; end
                OP_WRITE: begin is_rd_d = 1'b0; ph_d = PH_AHI; end
                default:  ph_d = PH_IGN;
              endcase
            end
          end
          PH_AHI: begin
            addr_d[ADDR_W-1:8] = in_byte[ADDR_W-9:0];
            ph_d = PH_ALO;
          end
          PH_ALO: begin
            addr_d[7:0] = in_byte;
            src_st_d    = 1'b0;
            pb_clr      = !is_rd_q;
            ph_d        = is_rd_q ? PH_OUT : PH_WDATA;
          end
          PH_WDATA: begin
            pb_wr    = 1'b1;
            wr_arm_d = 1'b1;
            addr_d[PAGE_W-1:0] = addr_q[PAGE_W-1:0] + 1'b1;
          end
          PH_SRDATA: begin
            srnew_d  = in_byte[3:2];
            sr_arm_d = 1'b1;
            ph_d     = PH_IGN;
          end
          default: ;
        endcase
      end
      if (fall && ph_q == PH_OUT) begin
        obit_d = obit_q + 3'd1;
        if (obit_q == 3'd0) begin
          if (src_st_q) osr_d = st_byte;
          else begin
            osr_d  = mem_rd;
            addr_d = addr_q + 1'b1;
          end
        end else begin
          osr_d = {osr_q[6:0], 1'b0};
        end
      end
    end

    if (wr_go) begin
      commit_d = 1'b1;
      page_d   = addr_q[ADDR_W-1:PAGE_W];
    end
    if (sr_go) bp_d = srnew_q;
    if (tm_done) begin
      commit_d = 1'b0;
      wel_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      sck_q <= 1'b0;  csn_q <= 1'b1;
      ph_q <= PH_OPC; bcnt_q <= 3'd0; obit_q <= 3'd0;
      sr_q <= '0;     addr_q <= '0;   osr_q <= '0;
      bp_q <= 2'b00;  srnew_q <= 2'b00; page_q <= '0;
      is_rd_q <= 1'b0; src_st_q <= 1'b0; wel_q <= 1'b0;
      wr_arm_q <= 1'b0; sr_arm_q <= 1'b0; commit_q <= 1'b0;
    end else begin
      sck_q <= sck_s;  csn_q <= csn_s;
      ph_q <= ph_d;    bcnt_q <= bcnt_d; obit_q <= obit_d;
      sr_q <= sr_d;    addr_q <= addr_d; osr_q <= osr_d;
      bp_q <= bp_d;    srnew_q <= srnew_d; page_q <= page_d;
      is_rd_q <= is_rd_d; src_st_q <= src_st_d; wel_q <= wel_d;
      wr_arm_q <= wr_arm_d; sr_arm_q <= sr_arm_d; commit_q <= commit_d;
    end
  end

  assign so    = osr_q[7];
  assign so_en = cs_act && !hold_act && (ph_q == PH_OUT);

  // R7: the array is never written inside the blocked range
  a_r7_no_blocked_write: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_we |-> !prot_hit(bp_q, mem_waddr[ADDR_W-1 -: 2]));
  // R5: a write cycle begins only with the enable latch set
  a_r5_latch_before_cycle: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(wip) |-> $past(wel_q));
  // R11: the latch is clear once the cycle ends
  a_r11_latch_cleared: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(wip) |-> !wel_q);
  // R8: protect field only moves while wp_n was high
  a_r8_wp_freezes: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(bp_q) |-> $past(wpn_s));
  // R9: the bit counter does not advance while held
  a_r9_hold_freezes: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cs_act && hold_act) |=> $stable(bcnt_q));
  // R10: deselect returns the command decoder to its start
  a_r10_deselect_resets: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(csn_s) |=> (ph_q == PH_OPC) && (bcnt_q == 3'd0));

endmodule

// File: tb/sim_spi_nvm_slave.sv
module sim_spi_nvm_slave;

  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;
  localparam int WRC   = 500;
  localparam int H     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, si = 1'b0, cs_n = 1'b1, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_en;

  always #10 clk = ~clk;

  spi_nvm_slave #(.ADDR_W(AW), .PAGE_W(5), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_en(so_en)
  );

  int  total = 0, bad = 0;
  bit  m3 = 1'b0;
  bit  finished = 1'b0;
  logic [7:0] mdl [DEPTH];
  bit         known [DEPTH];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit blocked(input logic [1:0] bp, input int a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= (DEPTH * 3) / 4;
      2'b10:   return a >= DEPTH / 2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] st_exp(input logic [1:0] bp, input bit wel, input bit wip);
    return {4'b0000, bp, wel, wip};
  endfunction

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_begin(input bit mode3);
    m3 = mode3;
    sck = mode3;
    tk(H);
    cs_n = 1'b0;
    tk(H);
  endtask

  task automatic spi_end();
    if (!m3) begin
      sck = 1'b0;
      tk(H);
    end
    cs_n = 1'b1;
    tk(4 * H);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      if (sck) sck = 1'b0;
      si = tx[i];
      tk(H);
      rx[i] = so;
      sck = 1'b1;
      tk(H);
    end
  endtask

  task automatic cmd1(input bit md, input logic [7:0] op);
    logic [7:0] r;
    spi_begin(md);
    xfer(op, r);
    spi_end();
  endtask

  task automatic rdsr(input bit md, output logic [7:0] s);
    logic [7:0] r;
    spi_begin(md);
    xfer(8'h05, r);
    xfer(8'h00, s);
    spi_end();
  endtask

  task automatic wrsr(input bit md, input logic [7:0] v);
    logic [7:0] r;
    spi_begin(md);
    xfer(8'h01, r);
    xfer(v, r);
    spi_end();
  endtask

  // WRITE of n random bytes; the model is updated only when a commit is expected
  task automatic page_write(input bit md, input int a, input int n, input bit expect_ok);
    logic [7:0] r, d;
    int idx;
    spi_begin(md);
    xfer(8'h02, r);
    xfer(8'(a >> 8), r);
    xfer(8'(a), r);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      xfer(d, r);
      idx = ((a & (DEPTH - 1)) & ~31) | ((a + i) & 31);
      if (expect_ok) begin
        mdl[idx] = d;
        known[idx] = 1'b1;
      end
    end
    spi_end();
  endtask

  task automatic seq_read(input bit md, input int a, input int n, input string req);
    logic [7:0] r;
    int idx;
    spi_begin(md);
    xfer(8'h03, r);
    xfer(8'(a >> 8), r);
    xfer(8'(a), r);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, r);
      idx = (a + i) & (DEPTH - 1);
      if (known[idx]) chk(r === mdl[idx], req, int'(r), int'(mdl[idx]));
    end
    spi_end();
  endtask

  task automatic wait_idle();
    tk(WRC + 50);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] s, r, r1, r2;
    int a, n;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;

    tk(5);
    rst_n = 1'b1;
    tk(10);

    // R10 / R6: reset state
    chk(so_en == 1'b0, "R10 so released after reset", so_en, 0);
    rdsr(0, s);
    chk(s == st_exp(2'b00, 0, 0), "R6 status after reset", s, st_exp(2'b00, 0, 0));

    // R5: latch set and clear
    cmd1(0, 8'h06);
    rdsr(0, s);
    chk(s == st_exp(2'b00, 1, 0), "R5 WREN sets latch", s, st_exp(2'b00, 1, 0));
    cmd1(1, 8'h04);
    rdsr(1, s);
    chk(s == st_exp(2'b00, 0, 0), "R5 WRDI clears latch", s, st_exp(2'b00, 0, 0));

    // R4 / R11: page write, busy flag, commands ignored while busy
    cmd1(0, 8'h06);
    page_write(0, 16'h0040, 4, 1);
    rdsr(0, s);
    chk(s == st_exp(2'b00, 1, 1), "R11 busy status during cycle", s, st_exp(2'b00, 1, 1));
    page_write(0, 16'h0040, 4, 0);   // ignored: opcode arrives while busy
    wait_idle();
    rdsr(0, s);
    chk(s == st_exp(2'b00, 0, 0), "R11 latch cleared after cycle", s, st_exp(2'b00, 0, 0));
    seq_read(0, 16'h0040, 4, "R4 page data after write, R11 busy write ignored");

    // R5: write with latch clear is ignored
    page_write(0, 16'h0040, 4, 0);
    tk(20);
    rdsr(0, s);
    chk(s == st_exp(2'b00, 0, 0), "R5 no cycle without latch", s, 0);
    seq_read(0, 16'h0040, 4, "R5 array unchanged without latch");

    // R4: wrap inside the page
    cmd1(0, 8'h06);
    page_write(0, 16'h009E, 5, 1);
    wait_idle();
    seq_read(0, 16'h0080, 32, "R4 page wrap");

    // R1: high address bits ignored
    seq_read(0, 16'hF840, 4, "R1 high address bits ignored");

    // R3: read wraps past the last address
    cmd1(0, 8'h06);
    page_write(0, DEPTH - 2, 2, 1);
    wait_idle();
    cmd1(0, 8'h06);
    page_write(0, 0, 2, 1);
    wait_idle();
    seq_read(0, DEPTH - 2, 4, "R3 read wrap to zero");

    // R2: mode 3 write and read
    cmd1(1, 8'h06);
    page_write(1, 16'h0123, 6, 1);
    wait_idle();
    seq_read(1, 16'h0123, 6, "R2 mode 3 transfer");
    seq_read(0, 16'h0123, 6, "R2 mode 0 read of mode 3 data");

    // R9: hold during a read
    spi_begin(0);
    xfer(8'h03, r);
    xfer(8'h01, r);
    xfer(8'h23, r);
    xfer(8'h00, r1);
    chk(so_en == 1'b1, "R9 so driven before hold", so_en, 1);
    hold_n = 1'b0;
    tk(H);
    chk(so_en == 1'b0, "R9 so released under hold", so_en, 0);
    sck = 1'b0; si = 1'b1; tk(H);
    sck = 1'b1; tk(H);
    sck = 1'b0; tk(H);
    sck = 1'b1; tk(H);
    hold_n = 1'b1;
    tk(H);
    xfer(8'h00, r2);
    spi_end();
    chk(r1 === mdl[16'h0123], "R9 byte before hold", r1, mdl[16'h0123]);
    chk(r2 === mdl[16'h0124], "R9 transfer resumes after hold", r2, mdl[16'h0124]);

    // R10: write aborted inside a data byte
    cmd1(0, 8'h06);
    spi_begin(0);
    xfer(8'h02, r);
    xfer(8'h01, r);
    xfer(8'h23, r);
    xfer(8'h5A, r);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b0; si = 1'b1; tk(H);
      sck = 1'b1; tk(H);
    end
    spi_end();
    tk(20);
    rdsr(0, s);
    chk(s == st_exp(2'b00, 1, 0), "R10 aborted write starts no cycle", s, st_exp(2'b00, 1, 0));
    seq_read(0, 16'h0123, 2, "R10 aborted write changes nothing");
    cmd1(0, 8'h04);

    // R7: protection ranges, with data placed first
    cmd1(0, 8'h06); page_write(0, 16'h0700, 2, 1); wait_idle();
    cmd1(0, 8'h06); page_write(0, 16'h0500, 2, 1); wait_idle();
    cmd1(0, 8'h06); page_write(0, 16'h0200, 2, 1); wait_idle();

    for (int b = 1; b < 4; b++) begin
      cmd1(0, 8'h06);
      wrsr(0, 8'(b << 2));
      wait_idle();
      rdsr(0, s);
      chk(s == st_exp(2'(b), 0, 0), "R8 status write loads field", s, st_exp(2'(b), 0, 0));
      foreach (a_list[k]) begin end
    end
    // back to none for the range tests
    cmd1(0, 8'h06); wrsr(0, 8'h00); wait_idle();

    for (int b = 1; b < 4; b++) begin
      cmd1(0, 8'h06);
      wrsr(0, 8'(b << 2));
      wait_idle();
      for (int k = 0; k < 3; k++) begin
        a = (k == 0) ? 16'h0700 : (k == 1) ? 16'h0500 : 16'h0200;
        cmd1(0, 8'h06);
        page_write(0, a, 2, !blocked(2'(b), a));
        tk(20);
        rdsr(0, s);
        chk(s[0] == !blocked(2'(b), a), "R7 cycle only for open range", s[0], !blocked(2'(b), a));
        if (s[0]) wait_idle(); else cmd1(0, 8'h04);
        seq_read(0, a, 2, "R7 protected bytes kept");
      end
      cmd1(0, 8'h06); wrsr(0, 8'h00); wait_idle();
    end

    // R8: wp_n freezes the field
    cmd1(0, 8'h06); wrsr(0, 8'h0C); wait_idle();
    wp_n = 1'b0;
    cmd1(0, 8'h06);
    wrsr(0, 8'h00);
    tk(20);
    rdsr(0, s);
    chk(s == st_exp(2'b11, 1, 0), "R8 status write rejected under wp_n", s, st_exp(2'b11, 1, 0));
    wp_n = 1'b1;
    wrsr(0, 8'h00);
    wait_idle();
    rdsr(0, s);
    chk(s == st_exp(2'b00, 0, 0), "R8 status write accepted after release", s, 0);

    // R1 / R2 / R4: constrained random writes and reads
    for (int it = 0; it < 10; it++) begin
      a = int'($urandom_range(DEPTH - 1, 0));
      n = int'($urandom_range(16, 1));
      cmd1(it[0], 8'h06);
      page_write(it[0], a | (int'($urandom_range(31, 0)) << AW), n, 1);
      wait_idle();
      seq_read(!it[0], a & ~31, 32, "R1 R2 R4 random page check");
    end

    chk(so_en == 1'b0, "R10 so released after deselect", so_en, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int a_list [1];

endmodule